// File: doc/BRIEF.md
# Multi-Rate Serial Codeword Port

This block is the serial side of one channel of a codeword transcoder that works at four rates. A slot strobe marks the channel's time slot, and a bit clock pulses while that strobe is high. On the receive side the block shifts serial bits in during the slot. When the strobe falls, it keeps the last N bits as the received codeword, where N (2, 3, 4 or 5) follows from a 2-bit rate select. It then presents that codeword right-aligned on a parallel port, together with a one-cycle valid pulse.

On the transmit side the block takes a parallel codeword from the transcoding core when the slot strobe rises and presents its MSB at once. Each further bit-clock rising edge moves the output on by one bit position. When the pulses outrun the codeword, the output starts again from the MSB. The three narrow rates repeat on a fixed four-bit frame padded with zeros. The five-bit rate repeats every five bits with no padding.

The strobe, the bit clock and the serial input are asynchronous to the system clock. They pass through a synchronizer of configurable depth, and the block finds their edges on the system clock. The transcoding arithmetic and the pad drivers sit outside this block.

Top module: `cw_serial_port`

## Requirements
- R1: The rate select sets the codeword width as follows: 2'b00 gives 4 bits, 2'b01 gives 3 bits, 2'b10 gives 2 bits and 2'b11 gives 5 bits. The receive side samples the rate when the slot strobe falls. The transmit side samples it when the slot strobe rises.
- R2: On a slot strobe falling edge, rx_word_o takes the last N serial bits received in that slot, with the last bit as the LSB in bit 0. Earlier bits of the slot are discarded, and bits N and above of rx_word_o are 0.
- R3: rx_valid_o is high for exactly one system clock for each slot strobe falling edge, in the same cycle in which rx_word_o takes its new value.
- R4: After the slot strobe rises, sdo_o presents the MSB of tx_word_i before any bit-clock edge occurs.
- R5: Each bit-clock rising edge while the slot strobe is high moves sdo_o to the next lower codeword bit. The order runs from MSB to LSB.
- R6: At the 4-, 3- and 2-bit rates, the output sequence repeats every 4 bit positions. Positions after the LSB within each group of 4 drive 0.
- R7: At the 5-bit rate, the output sequence repeats every 5 bit positions with no filler. With 8 positions the output is D4 D3 D2 D1 D0 D4 D3 D2.
- R8: While the slot strobe is low, bit-clock pulses neither change sdo_o nor produce rx_valid_o.
- R9: During and after reset, sdo_o, rx_valid_o and rx_word_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| frame_i | input | 1 | Slot strobe, high during the channel slot |
| bclk_i | input | 1 | Serial bit clock |
| sdi_i | input | 1 | Serial receive data, sampled on bit-clock falling edges |
| rate_i | input | 2 | Rate select (codeword width per R1) |
| tx_word_i | input | MAX_W (5) | Codeword to transmit, right-aligned |
| rx_word_o | output | MAX_W (5) | Received codeword, right-aligned |
| rx_valid_o | output | 1 | One-cycle pulse when rx_word_o updates |
| sdo_o | output | 1 | Serial transmit data |

## Verification
Each external edge passes through SYNC_STAGES synchronizer flops and one edge-detect register before the logic acts on it. With the default depth of two, a change applied just after a system clock edge takes effect at the third rising edge that follows. The bench therefore drives every input one time unit after a rising edge. It samples the serial output at the falling edge after the fourth rising edge, and it samples the valid pulse and the received word at the falling edge after the third rising edge. It then checks on the next falling edge that the pulse has ended. Each strobe and bit-clock level is held for four system clocks, and serial data settles two clocks before each bit-clock fall, so the synchronized data and clock never arrive in the same cycle.

// File: rtl/cw_port_pkg.sv
package cw_port_pkg;

   typedef enum logic [1:0] {
      RATE_W4 = 2'b00,
      RATE_W3 = 2'b01,
      RATE_W2 = 2'b10,
      RATE_W5 = 2'b11
   } rate_e;

   function automatic logic [2:0] width_of(input logic [1:0] rate);
      case (rate)
         RATE_W4: width_of = 3'd4;
         RATE_W3: width_of = 3'd3;
         RATE_W2: width_of = 3'd2;
         default: width_of = 3'd5;
      endcase
   endfunction

   function automatic logic [2:0] period_of(input logic [1:0] rate,
                                            input int unsigned pad_period);
      if (rate == RATE_W5) period_of = 3'd5;
      else                 period_of = 3'(pad_period);
   endfunction

endpackage

// File: rtl/cwp_sync.sv
module cwp_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("cwp_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) chain_q[i] <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int i = 1; i < int'(STAGES); i++) chain_q[i] <= chain_q[i-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cwp_rx.sv
module cwp_rx
   import cw_port_pkg::*;
#(
   parameter int unsigned MAX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_s,
   input  logic             frame_fall,
   input  logic             bclk_fall,
   input  logic             sdi_s,
   input  logic [1:0]       rate_i,
   output logic [MAX_W-1:0] word_o,
   output logic             valid_o
);
   logic [MAX_W-1:0] shift_q;
   logic [MAX_W-1:0] masked;
   logic [2:0]       cap_w;

   assign cap_w = width_of(rate_i);

   always_comb begin
      masked = '0;
      for (int i = 0; i < int'(MAX_W); i++)
         if (i < int'(cap_w)) masked[i] = shift_q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         word_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= frame_fall;
         if (frame_fall) word_o <= masked;
         if (frame_s && bclk_fall) shift_q <= {shift_q[MAX_W-2:0], sdi_s};
      end
   end

   p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
   p_valid_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_fall |=> valid_o);
   p_word_fits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_fall |=> ((word_o >> width_of($past(rate_i))) == '0));
   p_no_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_s && !frame_fall) |=> !valid_o);
endmodule

// File: rtl/cwp_tx.sv
module cwp_tx
   import cw_port_pkg::*;
#(
   parameter int unsigned MAX_W      = 5,
   parameter int unsigned PAD_PERIOD = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_s,
   input  logic             frame_rise,
   input  logic             bclk_rise,
   input  logic [1:0]       rate_i,
   input  logic [MAX_W-1:0] word_i,
   output logic             sdo_o
);
   localparam int unsigned IDX_W = $clog2(MAX_W);

   logic [MAX_W-1:0] word_q;
   logic [2:0]       width_q;
   logic [2:0]       period_q;
   logic [IDX_W-1:0] idx_q;
   logic             adv;

   assign adv = frame_s && bclk_rise && !frame_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q   <= '0;
         width_q  <= 3'd4;
         period_q <= 3'(PAD_PERIOD);
         idx_q    <= '0;
      end else if (frame_rise) begin
         word_q   <= word_i;
         width_q  <= width_of(rate_i);
         period_q <= period_of(rate_i, PAD_PERIOD);
         idx_q    <= '0;
      end else if (adv) begin
         if (32'(idx_q) == 32'(period_q) - 1) idx_q <= '0;
         else                                 idx_q <= idx_q + 1'b1;
      end
   end

   always_comb begin
      sdo_o = 1'b0;
      for (int i = 0; i < int'(MAX_W); i++)
         if (int'(idx_q) < int'(width_q) && i == int'(width_q) - 1 - int'(idx_q))
            sdo_o = word_q[i];
   end

   p_idx_in_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
      32'(idx_q) < 32'(period_q));
   p_load_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_rise |=> (idx_q == '0));
   p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && 32'(idx_q) == 32'(period_q) - 1) |=> (idx_q == '0));
   p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_s |=> $stable(sdo_o));
endmodule

// File: rtl/cw_serial_port.sv
module cw_serial_port
   import cw_port_pkg::*;
#(
   parameter int unsigned MAX_W       = 5,
   parameter int unsigned PAD_PERIOD  = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_i,
   input  logic             bclk_i,
   input  logic             sdi_i,
   input  logic [1:0]       rate_i,
   input  logic [MAX_W-1:0] tx_word_i,
   output logic [MAX_W-1:0] rx_word_o,
   output logic             rx_valid_o,
   output logic             sdo_o
);
   generate
      if (MAX_W < 5) begin : g_bad_w
         $error("cw_serial_port: MAX_W must hold the 5-bit rate");
      end
      if (PAD_PERIOD < 4 || PAD_PERIOD >= MAX_W + 1) begin : g_bad_pad
         $error("cw_serial_port: PAD_PERIOD out of range");
      end
   endgenerate

   logic [2:0] raw, synced;
   logic       frame_s, bclk_s, sdi_s;
   logic       frame_d, bclk_d;
   logic       frame_rise, frame_fall, bclk_rise, bclk_fall;

   assign raw = {frame_i, bclk_i, sdi_i};

   cwp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw),
      .q_o   (synced)
   );

   assign {frame_s, bclk_s, sdi_s} = synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_d <= 1'b0;
         bclk_d  <= 1'b1;
      end else begin
         frame_d <= frame_s;
         bclk_d  <= bclk_s;
      end
   end

   assign frame_rise = frame_s & ~frame_d;
   assign frame_fall = ~frame_s & frame_d;
   assign bclk_rise  = bclk_s & ~bclk_d;
   assign bclk_fall  = ~bclk_s & bclk_d;

   cwp_rx #(.MAX_W(MAX_W)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_s    (frame_s),
      .frame_fall (frame_fall),
      .bclk_fall  (bclk_fall),
      .sdi_s      (sdi_s),
      .rate_i     (rate_i),
      .word_o     (rx_word_o),
      .valid_o    (rx_valid_o)
   );

   cwp_tx #(.MAX_W(MAX_W), .PAD_PERIOD(PAD_PERIOD)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_s    (frame_s),
      .frame_rise (frame_rise),
      .bclk_rise  (bclk_rise),
      .rate_i     (rate_i),
      .word_i     (tx_word_i),
      .sdo_o      (sdo_o)
   );

   p_edges_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_rise && frame_fall));
endmodule

// File: tb/sim_cw_serial_port.sv
`timescale 1ns/1ps
module sim_cw_serial_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_i = 1'b0;
   logic       bclk_i = 1'b1;
   logic       sdi_i = 1'b0;
   logic [1:0] rate_i = 2'b00;
   logic [4:0] tx_word_i = '0;
   logic [4:0] rx_word_o;
   logic       rx_valid_o;
   logic       sdo_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cw_serial_port u0 (
      .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .bclk_i(bclk_i),
      .sdi_i(sdi_i), .rate_i(rate_i), .tx_word_i(tx_word_i),
      .rx_word_o(rx_word_o), .rx_valid_o(rx_valid_o), .sdo_o(sdo_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic waitpos(input int n);
      repeat (n) @(posedge clk);
   endtask

   function automatic int wid(input logic [1:0] r);
      case (r)
         2'b00: return 4;
         2'b01: return 3;
         2'b10: return 2;
         default: return 5;
      endcase
   endfunction

   function automatic logic exp_bit(input logic [1:0] r, input logic [4:0] w, input int k);
      int p = (r == 2'b11) ? 5 : 4;
      int m = k % p;
      int n = wid(r);
      return (m < n) ? w[n-1-m] : 1'b0;
   endfunction

   // one slot: strobe high, np bit-clock low pulses, strobe low
   task automatic run_slot(input logic [1:0] r, input logic [4:0] txw,
                           input logic [15:0] rxbits, input int np);
      int n = wid(r);
      logic [4:0] exp_rx = '0;
      step();
      rate_i = r; tx_word_i = txw;
      waitpos(2);
      step();
      frame_i = 1'b1;
      waitpos(4); @(negedge clk);
      chk("R4 msb after strobe rise", 32'(sdo_o), 32'(exp_bit(r, txw, 0)));
      for (int k = 0; k < np; k++) begin
         step(); sdi_i = rxbits[np-1-k];
         waitpos(1);
         step(); bclk_i = 1'b0;
         waitpos(3);
         step(); bclk_i = 1'b1;
         waitpos(3); @(negedge clk);
         if (((k + 1) % ((r == 2'b11) ? 5 : 4)) < n)
            chk((r == 2'b11) ? "R5 R7 bit order" : "R5 R6 bit order",
                32'(sdo_o), 32'(exp_bit(r, txw, k + 1)));
         else
            chk("R6 zero filler", 32'(sdo_o), 32'(exp_bit(r, txw, k + 1)));
      end
      for (int i = 0; i < n; i++) exp_rx[i] = rxbits[i];
      step(); frame_i = 1'b0;
      waitpos(3); @(negedge clk);
      chk("R3 valid pulse", 32'(rx_valid_o), 32'd1);
      chk("R1 R2 rx word", 32'(rx_word_o), 32'(exp_rx));
      @(negedge clk);
      chk("R3 valid one cycle", 32'(rx_valid_o), 32'd0);
   endtask

   task automatic t_reset();
      waitpos(3);
      @(negedge clk);
      chk("R9 sdo reset", 32'(sdo_o), 32'd0);
      chk("R9 valid reset", 32'(rx_valid_o), 32'd0);
      chk("R9 word reset", 32'(rx_word_o), 32'd0);
      step(); rst_n = 1'b1;
      waitpos(4); @(negedge clk);
      chk("R9 sdo after reset", 32'(sdo_o), 32'd0);
      chk("R9 valid after reset", 32'(rx_valid_o), 32'd0);
   endtask

   task automatic t_idle_pulses();
      logic held = sdo_o;
      logic saw_valid = 1'b0;
      for (int k = 0; k < 6; k++) begin
         step(); bclk_i = 1'b0; sdi_i = k[0];
         repeat (4) begin @(negedge clk); if (rx_valid_o) saw_valid = 1'b1; end
         step(); bclk_i = 1'b1;
         repeat (4) begin @(negedge clk); if (rx_valid_o) saw_valid = 1'b1; end
      end
      chk("R8 sdo held with strobe low", 32'(sdo_o), 32'(held));
      chk("R8 no valid with strobe low", 32'(saw_valid), 32'd0);
   endtask

   initial begin
      t_reset();
      run_slot(2'b00, 5'b01011, 16'h005A, 4);   // R1 4-bit, exact length
      run_slot(2'b00, 5'b00110, 16'h00E9, 8);   // R6 recirculation
      run_slot(2'b01, 5'b00101, 16'h0036, 8);   // R6 3-bit with filler
      run_slot(2'b10, 5'b00010, 16'h0053, 7);   // R6 2-bit with filler
      run_slot(2'b11, 5'b10110, 16'h00B3, 8);   // R7 5-bit recirculation
      run_slot(2'b11, 5'b01001, 16'h0011, 5);   // R7 exact length
      t_idle_pulses();
      run_slot(2'b01, 5'b00011, 16'h0002, 3);   // R2 upper bits zero
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule